// File: doc/BRIEF.md
# Five-Channel Register-Mapped Serial Port Bank

This block gives a host microcontroller five independent asynchronous serial channels through one small parallel register window. The window has a chip select, a read/not-write line, a 6-bit address and separate 8-bit data-in and data-out buses. Each channel has these parts:
- a one-byte receive holding register,
- a transmit shift register that starts sending as soon as a byte is written,
- a bit in each of the shared status, mask and frame-error registers.

One level interrupt output goes high whenever an unmasked channel holds a received byte.

All channels use the same 10-bit frame: a low start bit, eight data bits sent least significant bit first, and a high stop bit. A shared divider makes a tick at sixteen times the bit rate. Receivers wait for the middle of the start bit to confirm it, then sample each later bit sixteen ticks after the one before.

A port-mode input selects the debug monitoring arrangement. When it is low, an auxiliary channel listens to both directions of the transceiver channel's link, and its transmitter also drives the transceiver's output pin. When it is high, every channel stands alone.

Top module: `uartBank`

## Requirements
- R1: Writing address n (0 to 4) with chip select high and the read/not-write line low starts channel n sending that byte at once. The frame is start bit 0, eight data bits least significant bit first, then stop bit 1. Each bit lasts 16*CLK_DIV clock cycles, and the line idles high.
- R2: Bit n of address 0x11 reads 1 while channel n is idle and 0 while it is sending. A write to channel n while it is sending is ignored: the frame in progress is unchanged and no second frame follows.
- R3: After a complete frame arrives on channel n, bit n of address 0x10 reads 1, and address n returns the received byte.
- R4: Reading address n clears bit n of address 0x10.
- R5: A low pulse on a receive line that is shorter than half a bit does not produce a byte.
- R6: A frame whose sampled stop bit is 0 sets bit n of address 0x13. Reading address 0x13 clears every flag in it.
- R7: Address 0x12 is a read/write mask, one bit per channel. The interrupt output equals the OR over all channels of (bit n of 0x10 AND mask bit n).
- R8: With the port-mode input at 0, channel 1 receives the logical AND of receive line 0 and channel 0's transmitter. Transmit pin 0 carries the AND of the channel 0 and channel 1 transmitters. So channel 1 captures bytes arriving on link 0 and bytes sent by channel 0, and bytes sent by channel 1 appear on transmit pin 0.
- R9: With the port-mode input at 1, every channel uses only its own pins. Traffic on link 0 does not reach channel 1, and channel 1 does not drive transmit pin 0.
- R10: After reset, addresses 0x10, 0x12 and 0x13 read 0 and address 0x11 reads 0x1F. The interrupt output is low and all transmit pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high, one cycle per access |
| rnw | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Register address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data, combinational while cs and rnw are high, otherwise 0 |
| irq | output | 1 | Level interrupt toward the host |
| splitPorts | input | 1 | 1 = independent channels, 0 = monitor arrangement |
| rxd | input | 5 | Serial receive lines, one per channel |
| txd | output | 5 | Serial transmit lines, one per channel |

## Verification
The assertions assume three things about the inputs:
- each host access lasts exactly one cycle of chip select, so a read-clear strobe never spans several cycles;
- the port-mode input changes only while both affected channels are idle;
- receive lines carry only whole frames or isolated short glitches, with idle time between them.

The bench keeps to this. Every bus access is a single-cycle task. The mode is changed only between frames. Each injected frame ends with at least one idle bit. An error frame holds its low stop bit for less than a full bit, so the tail of that bit cannot be taken for a new start bit.

// File: rtl/uartBankPkg.sv
package uartBankPkg;
  localparam int NUM_CH = 5;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] ADDR_RXRDY  = 6'h10;
  localparam logic [ADDR_W-1:0] ADDR_TXIDLE = 6'h11;
  localparam logic [ADDR_W-1:0] ADDR_MASK   = 6'h12;
  localparam logic [ADDR_W-1:0] ADDR_FERR   = 6'h13;

  // Control-to-datapath strobes, each valid for one clock
  typedef struct packed {
    logic [NUM_CH-1:0] txLoad;
    logic [NUM_CH-1:0] rxAck;
    logic              maskWr;
    logic              errClr;
  } strobe_t;
endpackage

// File: rtl/uartBankCtrl.sv
module uartBankCtrl
  import uartBankPkg::*;
(
  input  logic                     cs,
  input  logic                     rnw,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NUM_CH-1:0]        rxReady,
  input  logic [NUM_CH-1:0]        txIdle,
  input  logic [NUM_CH-1:0]        mask,
  input  logic [NUM_CH-1:0]        frameErr,
  input  logic [NUM_CH*DATA_W-1:0] rxData,
  output strobe_t                  stb,
  output logic [DATA_W-1:0]        dataOut
);
  logic rdAcc, wrAcc;
  assign rdAcc = cs & rnw;
  assign wrAcc = cs & ~rnw;

  always_comb begin
    stb     = '0;
    dataOut = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (addr == ADDR_W'(ch)) begin
        stb.txLoad[ch] = wrAcc;
        stb.rxAck[ch]  = rdAcc;
        if (rdAcc) dataOut = rxData[ch*DATA_W +: DATA_W];
      end
    end
    stb.maskWr = wrAcc && (addr == ADDR_MASK);
    stb.errClr = rdAcc && (addr == ADDR_FERR);
    if (rdAcc) begin
      if (addr == ADDR_RXRDY)  dataOut = DATA_W'(rxReady);
      if (addr == ADDR_TXIDLE) dataOut = DATA_W'(txIdle);
      if (addr == ADDR_MASK)   dataOut = DATA_W'(mask);
      if (addr == ADDR_FERR)   dataOut = DATA_W'(frameErr);
    end
  end
endmodule

// File: rtl/uartChannel.sv
module uartChannel #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              rxLine,
  input  logic              txLoad,
  input  logic [DATA_W-1:0] txByte,
  output logic              txLine,
  output logic              txBusy,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxDone,
  output logic              rxFerr
);
  localparam int BIT_W   = $clog2(DATA_W + 2);
  localparam int FRAME_B = DATA_W + 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;

  rxState_t          rxState;
  logic [1:0]        rxSync;
  logic [3:0]        rxPhase;
  logic [BIT_W-1:0]  rxIdx;
  logic [DATA_W-1:0] rxShift;
  logic              rxBit;

  assign rxBit = rxSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxSync  <= 2'b11;
      rxPhase <= '0;
      rxIdx   <= '0;
      rxShift <= '0;
      rxByte  <= '0;
      rxDone  <= 1'b0;
      rxFerr  <= 1'b0;
    end else begin
      rxSync <= {rxSync[0], rxLine};
      rxDone <= 1'b0;
      if (tick) begin
        rxPhase <= rxPhase + 4'd1;
        unique case (rxState)
          RX_IDLE: begin
            rxPhase <= '0;
            if (!rxBit) rxState <= RX_START;
          end
          RX_START: if (rxPhase == 4'd7) begin
            rxPhase <= '0;
            rxIdx   <= '0;
            rxState <= rxBit ? RX_IDLE : RX_DATA;
          end
          RX_DATA: if (rxPhase == 4'd15) begin
            rxShift <= {rxBit, rxShift[DATA_W-1:1]};
            rxIdx   <= rxIdx + 1'b1;
            if (rxIdx == BIT_W'(DATA_W - 1)) rxState <= RX_STOP;
          end
          RX_STOP: if (rxPhase == 4'd15) begin
            rxByte  <= rxShift;
            rxDone  <= 1'b1;
            rxFerr  <= !rxBit;
            rxState <= RX_IDLE;
          end
        endcase
      end
    end
  end

  logic [FRAME_B-1:0] txShift;
  logic [3:0]         txPhase;
  logic [BIT_W-1:0]   txIdx;

  assign txLine = txBusy ? txShift[0] : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
      txPhase <= '0;
      txIdx   <= '0;
      txBusy  <= 1'b0;
    end else if (txLoad && !txBusy) begin
      txShift <= {1'b1, txByte, 1'b0};
      txPhase <= '0;
      txIdx   <= '0;
      txBusy  <= 1'b1;
    end else if (txBusy && tick) begin
      txPhase <= txPhase + 4'd1;
      if (txPhase == 4'd15) begin
        txShift <= {1'b1, txShift[FRAME_B-1:1]};
        txIdx   <= txIdx + 1'b1;
        if (txIdx == BIT_W'(FRAME_B - 1)) txBusy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uartBankDp.sv
module uartBankDp
  import uartBankPkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int XCVR_CH = 0,
  parameter int AUX_CH  = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [DATA_W-1:0]        dataIn,
  input  logic                     splitPorts,
  input  logic [NUM_CH-1:0]        rxd,
  output logic [NUM_CH-1:0]        txd,
  output logic [NUM_CH-1:0]        rxReady,
  output logic [NUM_CH-1:0]        txBusy,
  output logic [NUM_CH-1:0]        mask,
  output logic [NUM_CH-1:0]        frameErr,
  output logic [NUM_CH-1:0]        rxDone,
  output logic [NUM_CH*DATA_W-1:0] rxData,
  output logic                     irq
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DIV_W-1:0]  divCnt;
  logic              tick;
  logic [NUM_CH-1:0] txLine, rxSrc, rxFerr;

  assign tick = (divCnt == DIV_W'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    if (ch == AUX_CH) begin : g_aux
      assign rxSrc[ch] = splitPorts ? rxd[ch] : (rxd[XCVR_CH] & txLine[XCVR_CH]);
    end else begin : g_plainRx
      assign rxSrc[ch] = rxd[ch];
    end
    if (ch == XCVR_CH) begin : g_xcvr
      assign txd[ch] = splitPorts ? txLine[ch] : (txLine[ch] & txLine[AUX_CH]);
    end else begin : g_plainTx
      assign txd[ch] = txLine[ch];
    end

    uartChannel #(.DATA_W(DATA_W)) chan_i (
      .clk(clk), .rstN(rstN), .tick(tick), .rxLine(rxSrc[ch]),
      .txLoad(stb.txLoad[ch]), .txByte(dataIn), .txLine(txLine[ch]),
      .txBusy(txBusy[ch]), .rxByte(rxData[ch*DATA_W +: DATA_W]),
      .rxDone(rxDone[ch]), .rxFerr(rxFerr[ch])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReady  <= '0;
      mask     <= '0;
      frameErr <= '0;
    end else begin
      rxReady  <= (rxReady & ~stb.rxAck) | rxDone;
      frameErr <= (stb.errClr ? '0 : frameErr) | (rxDone & rxFerr);
      if (stb.maskWr) mask <= dataIn[NUM_CH-1:0];
    end
  end

  assign irq = |(rxReady & mask);
endmodule

// File: rtl/uartBank.sv
module uartBank
  import uartBankPkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int XCVR_CH = 0,
  parameter int AUX_CH  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              rnw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              irq,
  input  logic              splitPorts,
  input  logic [NUM_CH-1:0] rxd,
  output logic [NUM_CH-1:0] txd
);
  strobe_t                  stb;
  logic [NUM_CH-1:0]        rxReady, txBusy, mask, frameErr, rxDone;
  logic [NUM_CH*DATA_W-1:0] rxData;

  uartBankCtrl ctrl_i (
    .cs(cs), .rnw(rnw), .addr(addr), .rxReady(rxReady), .txIdle(~txBusy),
    .mask(mask), .frameErr(frameErr), .rxData(rxData), .stb(stb), .dataOut(dataOut)
  );

  uartBankDp #(.CLK_DIV(CLK_DIV), .XCVR_CH(XCVR_CH), .AUX_CH(AUX_CH)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .dataIn(dataIn), .splitPorts(splitPorts),
    .rxd(rxd), .txd(txd), .rxReady(rxReady), .txBusy(txBusy), .mask(mask),
    .frameErr(frameErr), .rxDone(rxDone), .rxData(rxData), .irq(irq)
  );
endmodule

// File: rtl/uartBankChk.sv
module uartBankChk
  import uartBankPkg::*;
#(
  parameter int XCVR_CH = 0,
  parameter int AUX_CH  = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              splitPorts,
  input logic              irq,
  input logic [NUM_CH-1:0] txd,
  input strobe_t           stb,
  input logic [NUM_CH-1:0] rxReady,
  input logic [NUM_CH-1:0] txBusy,
  input logic [NUM_CH-1:0] mask,
  input logic [NUM_CH-1:0] frameErr,
  input logic [NUM_CH-1:0] rxDone
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_tx_start_R1: assert property (@(posedge clk) disable iff (!rstN)
      stb.txLoad[c] && !txBusy[c] |=> txBusy[c] && !txd[c]);

    if (c != XCVR_CH) begin : g_idle
      assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rstN)
        !txBusy[c] |-> txd[c]);
    end

    assert_rx_set_R3: assert property (@(posedge clk) disable iff (!rstN)
      rxDone[c] |=> rxReady[c]);

    assert_rx_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
      stb.rxAck[c] && !rxDone[c] |=> !rxReady[c]);
  end

  assert_ferr_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.errClr && (rxDone == '0) |=> frameErr == '0);

  assert_mask_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    mask == '0 |-> !irq);

  assert_mirror_tx_R8: assert property (@(posedge clk) disable iff (!rstN)
    !splitPorts && !txd[AUX_CH] |-> !txd[XCVR_CH]);
endmodule

bind uartBank uartBankChk #(.XCVR_CH(XCVR_CH), .AUX_CH(AUX_CH)) chk_i (
  .clk(clk), .rstN(rstN), .splitPorts(splitPorts), .irq(irq), .txd(txd),
  .stb(stb), .rxReady(rxReady), .txBusy(txBusy), .mask(mask),
  .frameErr(frameErr), .rxDone(rxDone)
);

// File: tb/uartBank_tb_top.sv
module uartBank_tb_top;
  localparam int CLK_P   = 10;
  localparam int DIV     = 2;
  localparam int BIT_CLK = 16 * DIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cs = 1'b0, rnw = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic       irq;
  logic       splitPorts = 1'b1;
  logic [4:0] rxd = 5'h1F;
  logic [4:0] txd;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  uartBank #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .cs(cs), .rnw(rnw), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .irq(irq), .splitPorts(splitPorts), .rxd(rxd), .txd(txd)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1'b1; rnw = 1'b0; addr = a; dataIn = d;
    @(negedge clk); cs = 1'b0; rnw = 1'b1;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1'b1; rnw = 1'b1; addr = a;
    #(CLK_P/4); d = dataOut;
    @(negedge clk); cs = 1'b0;
  endtask

  // Drive one frame on rxd[ch]; a bad stop bit is held for 3/4 of a bit
  task automatic sendRx(input int ch, input logic [7:0] b, input bit goodStop);
    @(negedge clk);
    rxd[ch] = 1'b0; repeat (BIT_CLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd[ch] = b[i]; repeat (BIT_CLK) @(negedge clk);
    end
    rxd[ch] = goodStop;
    repeat (goodStop ? BIT_CLK : (BIT_CLK * 3) / 4) @(negedge clk);
    rxd[ch] = 1'b1; repeat (2 * BIT_CLK) @(negedge clk);
  endtask

  // Capture one frame from txd[ch]; returns data, start seen, stop value
  task automatic grabTx(input int ch, output logic [7:0] b, output bit seen, output bit stopV);
    int waitN = 0;
    b = '0; seen = 1'b0; stopV = 1'b0;
    while (txd[ch] && waitN < 12 * BIT_CLK) begin
      @(negedge clk); waitN++;
    end
    if (txd[ch]) return;
    repeat (BIT_CLK / 2) @(negedge clk);
    seen = !txd[ch];
    for (int i = 0; i < 8; i++) begin
      repeat (BIT_CLK) @(negedge clk);
      b[i] = txd[ch];
    end
    repeat (BIT_CLK) @(negedge clk);
    stopV = txd[ch];
  endtask

  // Count low samples on txd[ch] over n clocks
  task automatic lowCount(input int ch, input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!txd[ch]) lows++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd, got, pat;
    bit seen, stopV;
    int lows;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R10 reset state
    busRead(6'h10, rd); check(rd == 8'h00, "R10 rxReady", rd, 0);
    busRead(6'h11, rd); check(rd == 8'h1F, "R10 txIdle", rd, 8'h1F);
    busRead(6'h12, rd); check(rd == 8'h00, "R10 mask", rd, 0);
    busRead(6'h13, rd); check(rd == 8'h00, "R10 frameErr", rd, 0);
    check(irq == 1'b0, "R10 irq", irq, 0);
    check(txd == 5'h1F, "R10 txd idle", txd, 5'h1F);

    // R1/R2 transmit sweep with an ignored second write
    for (int ch = 0; ch < 5; ch++) begin
      for (int k = 0; k < 3; k++) begin
        pat = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (8'h5A ^ 8'(ch * 17));
        busWrite(6'(ch), pat);
        busRead(6'h11, rd);
        check(rd == (8'h1F & ~(8'd1 << ch)), "R2 busy flag", rd, 8'h1F & ~(8'd1 << ch));
        busWrite(6'(ch), ~pat);
        grabTx(ch, got, seen, stopV);
        check(seen, "R1 start bit", seen, 1);
        check(got == pat, "R1 data bits", got, pat);
        check(stopV, "R1 stop bit", stopV, 1);
        repeat (BIT_CLK) @(negedge clk);
        busRead(6'h11, rd); check(rd == 8'h1F, "R2 idle after frame", rd, 8'h1F);
        if (k == 2) begin
          lowCount(ch, 11 * BIT_CLK, lows);
          check(lows == 0, "R2 write during busy ignored", lows, 0);
        end
      end
    end

    // R3/R4/R7 receive sweep with all channels unmasked
    busWrite(6'h12, 8'h1F);
    busRead(6'h12, rd); check(rd == 8'h1F, "R7 mask readback", rd, 8'h1F);
    for (int ch = 0; ch < 5; ch++) begin
      for (int k = 0; k < 2; k++) begin
        pat = (k == 0) ? (8'h81 ^ 8'(ch << 2)) : 8'(ch * 53 + 7);
        sendRx(ch, pat, 1'b1);
        busRead(6'h10, rd);
        if (ch == 0) rd = rd & 8'hFD;   // channel 1 is independent here anyway
        check(rd == (8'd1 << ch), "R3 rxReady bit", rd, 8'd1 << ch);
        check(irq == 1'b1, "R7 irq set", irq, 1);
        busRead(6'(ch), rd); check(rd == pat, "R3 received byte", rd, pat);
        busRead(6'h10, rd); check(rd == 8'h00, "R4 cleared on read", rd, 0);
        check(irq == 1'b0, "R7 irq cleared", irq, 0);
      end
    end

    // R7 mask gating
    busWrite(6'h12, 8'h00);
    sendRx(2, 8'h3C, 1'b1);
    check(irq == 1'b0, "R7 masked irq", irq, 0);
    busWrite(6'h12, 8'h04);
    check(irq == 1'b1, "R7 unmask raises irq", irq, 1);
    busWrite(6'h12, 8'h1B);
    check(irq == 1'b0, "R7 other masks", irq, 0);
    busRead(6'd2, rd); check(rd == 8'h3C, "R3 masked byte kept", rd, 8'h3C);

    // R5 short glitch
    @(negedge clk); rxd[3] = 1'b0; repeat (BIT_CLK / 4) @(negedge clk); rxd[3] = 1'b1;
    repeat (12 * BIT_CLK) @(negedge clk);
    busRead(6'h10, rd); check(rd == 8'h00, "R5 glitch rejected", rd, 0);

    // R6 frame error and clear on read
    sendRx(4, 8'h96, 1'b0);
    busRead(6'h13, rd); check(rd == 8'h10, "R6 frame error set", rd, 8'h10);
    busRead(6'h13, rd); check(rd == 8'h00, "R6 cleared on read", rd, 0);
    busRead(6'd4, rd);
    sendRx(4, 8'h69, 1'b1);
    busRead(6'h13, rd); check(rd == 8'h00, "R6 good frame no error", rd, 0);
    busRead(6'd4, rd); check(rd == 8'h69, "R6 byte after error", rd, 8'h69);

    // R9 independent ports
    busRead(6'd0, rd); busRead(6'd1, rd);
    sendRx(0, 8'hC3, 1'b1);
    busRead(6'h10, rd); check(rd == 8'h01, "R9 no tap on ch1", rd, 8'h01);
    busRead(6'd0, rd);
    busWrite(6'd1, 8'h00);
    lowCount(0, 11 * BIT_CLK, lows);
    check(lows == 0, "R9 ch1 does not drive txd0", lows, 0);

    // R8 monitor arrangement
    splitPorts = 1'b0;
    repeat (4) @(negedge clk);
    sendRx(0, 8'h5E, 1'b1);
    busRead(6'h10, rd); check(rd == 8'h03, "R8 tap incoming", rd, 8'h03);
    busRead(6'd1, rd); check(rd == 8'h5E, "R8 aux got incoming byte", rd, 8'h5E);
    busRead(6'd0, rd);
    busWrite(6'd0, 8'hA7);
    grabTx(0, got, seen, stopV);
    check(got == 8'hA7, "R8 ch0 transmit on txd0", got, 8'hA7);
    repeat (2 * BIT_CLK) @(negedge clk);
    busRead(6'h10, rd); check(rd == 8'h02, "R8 tap outgoing", rd, 8'h02);
    busRead(6'd1, rd); check(rd == 8'hA7, "R8 aux got outgoing byte", rd, 8'hA7);
    busWrite(6'd1, 8'h2D);
    grabTx(0, got, seen, stopV);
    check(seen && got == 8'h2D, "R8 aux injects on txd0", got, 8'h2D);

    repeat (2 * BIT_CLK) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule